// File: doc/BRIEF.md
# Add/Subtract Unit with Carry, Overflow and Range Trap

This block is the integer add/subtract stage of a small RISC core. In one cycle it produces the sum, the sum with carry, or the difference of two operands. The second operand is either a register value or a short immediate that is sign-extended to the data width. Alongside the result it computes the unsigned carry/borrow flag and the signed overflow flag, and it holds both in a small status register.

Every accepted arithmetic operation rewrites both flags. When the overflow-exception enable is set and either new flag is 1, the block raises a range-trap request for one cycle. The result is combinational, so the core's writeback sees it in the same cycle. The flags and the trap pulse become visible after the next rising clock edge. The core feeds the stored carry back on `carry_in` for add-with-carry. Register file access, trap vectoring and pipeline flushing belong to the surrounding core.

Top module: `addsub_flag_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (add), `result_o` equals `opnd_a + B` modulo 2^DATA_W. After the clock edge that accepts the operation, `carry_o` holds the carry out of the unsigned sum.
- R2: For add, `ovf_o` becomes 1 exactly when both operands have the same sign bit and the result's sign bit differs from it.
- R3: With `op_sel` = 2'b01 (add with carry), `carry_in` is added as a third input. `carry_o` becomes the carry out of that three-input sum, and `ovf_o` follows the rule of R2.
- R4: With `op_sel` = 2'b10 (subtract), `result_o` equals `opnd_a - B` modulo 2^DATA_W. `carry_o` becomes 1 exactly when `opnd_a` is less than B under unsigned comparison.
- R5: For subtract, `ovf_o` becomes 1 exactly when the operands differ in sign and the result's sign differs from the sign of `opnd_a`.
- R6: With `imm_sel` = 1, B is `imm` sign-extended from IMM_W bits and `opnd_b` is ignored. With `imm_sel` = 0, B is `opnd_b`. The flag rules are the same for both forms.
- R7: Both flags are written on the rising edge of every cycle with `op_valid` = 1 and an arithmetic code, and each flag whose condition is not met is cleared. When `op_valid` = 0, the flags hold their values.
- R8: `range_trap_o` is 1 for exactly the one cycle after an accepted arithmetic operation whose new carry or new overflow is 1 while `ove_in` = 1. When `ove_in` = 0, the flags still update and no trap is raised.
- R9: `op_sel` = 2'b11 is not an arithmetic operation. Even with `op_valid` = 1 it leaves both flags unchanged and raises no trap.
- R10: While `rst_n` is low at a rising edge, `carry_o`, `ovf_o` and `range_trap_o` are cleared.
- R11: A zero operand gets no special treatment. Its value enters the arithmetic and the flag rules exactly as presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation is issued this cycle |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 no operation |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second register operand |
| imm | input | IMM_W | Immediate, sign-extended when selected |
| imm_sel | input | 1 | Use the immediate in place of `opnd_b` |
| carry_in | input | 1 | Current stored carry, used by add with carry |
| ove_in | input | 1 | Overflow-exception enable |
| result_o | output | DATA_W | Arithmetic result (combinational) |
| carry_o | output | 1 | Stored carry/borrow flag |
| ovf_o | output | 1 | Stored signed-overflow flag |
| range_trap_o | output | 1 | One-cycle range-trap request |

## Verification
The bench runs the block at a 6-bit data width with a 3-bit immediate, so add and subtract can be swept over every operand pair. Add with carry is swept over every pair with both carry inputs. This separates the unsigned carry from the signed overflow and the borrow from the subtract overflow, which at the wider default width only meet at a few corners. The immediate sweep covers every immediate value, including the negative codes, against every first operand, with a changing `opnd_b` that must have no effect. This shows that sign extension and operand selection are correct. Directed sequences alternate trapping and non-trapping operations with idle cycles and no-operation codes, to show that the flags hold and that the trap lasts one cycle and needs the enable.

// File: rtl/addsub_pkg.sv
// Package: shared operation codes and flag bundle for the add/subtract unit.
// Assumes a two-bit operation field driven by the issuing decoder.
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_SUB  = 2'b10,
        OP_NONE = 2'b11
    } arith_op_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } flag_pair_t;

endpackage

// File: rtl/addsub_operand_sel.sv
// Module: picks the second operand, either the register value or the
// immediate sign-extended to the data width.
// Assumes IMM_W <= DATA_W.
module addsub_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              use_imm,
    output logic [DATA_W-1:0] opnd_out
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            // Replicate the immediate's sign bit into the upper bits.
            assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        end else begin : g_same
            // Immediate already spans the data width.
            assign imm_ext = imm_val;
        end
    endgenerate

    // Operand multiplexer.
    assign opnd_out = use_imm ? imm_ext : reg_val;

endmodule

// File: rtl/addsub_core.sv
// Module: combinational add / add-with-carry / subtract datapath.
// Produces the result, the new carry/borrow and overflow bits, and an
// update enable that is high for arithmetic codes only.
module addsub_core
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  arith_op_e         op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cy_in,
    output logic [DATA_W-1:0] result,
    output flag_pair_t        flags,
    output logic              upd_en
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] ext;
    logic            cin_used;

    // Carry-in only participates in add with carry.
    assign cin_used = (op == OP_ADDC) && cy_in;

    // One extended-width adder/subtractor; the top bit is carry or borrow.
    always_comb begin
        ext         = '0;
        flags.carry = 1'b0;
        flags.ovf   = 1'b0;
        upd_en      = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                ext         = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin_used};
                flags.carry = ext[DATA_W];
                flags.ovf   = (a[MSB] == b[MSB]) && (ext[MSB] != a[MSB]);
                upd_en      = 1'b1;
            end
            OP_SUB: begin
                ext         = {1'b0, a} - {1'b0, b};
                flags.carry = ext[DATA_W];
                flags.ovf   = (a[MSB] != b[MSB]) && (ext[MSB] != a[MSB]);
                upd_en      = 1'b1;
            end
            default: begin
                ext = {1'b0, a} + {1'b0, b};
            end
        endcase
        result = ext[MSB:0];
    end

endmodule

// File: rtl/addsub_flag_reg.sv
// Module: status flag register and range-trap pulse generator.
// Flags load only on accepted arithmetic operations; the trap is a
// registered one-cycle pulse aligned with the flag update.
module addsub_flag_reg
    import addsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic       upd_en,
    input  flag_pair_t new_flags,
    input  logic       ove,
    output logic       carry_q,
    output logic       ovf_q,
    output logic       trap_q
);
    logic take;

    // An operation is taken when issued with an arithmetic code.
    assign take = op_valid && upd_en;

    // Flag storage and trap pulse, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
            trap_q  <= 1'b0;
        end else begin
            trap_q <= take && ove && (new_flags.carry || new_flags.ovf);
            if (take) begin
                carry_q <= new_flags.carry;
                ovf_q   <= new_flags.ovf;
            end
        end
    end

    // R8: a trap pulse is always accompanied by a set flag.
    assert_trap_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_q |-> (carry_q || ovf_q));

    // R7: with no operation issued the flags hold and no trap follows.
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable({carry_q, ovf_q}) && !trap_q));

    // R8: the enable gates the trap.
    assert_trap_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ove) |=> !trap_q);

endmodule

// File: rtl/addsub_flag_unit.sv
// Module: top of the add/subtract unit with carry, overflow and range trap.
// Assumes the core feeds the stored carry back on carry_in and samples
// result_o in the issue cycle; flags and trap appear after the next edge.
module addsub_flag_unit
    import addsub_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              imm_sel,
    input  logic              carry_in,
    input  logic              ove_in,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic              range_trap_o
);
    arith_op_e         op;
    logic [DATA_W-1:0] b_sel;
    flag_pair_t        nxt_flags;
    logic              upd_en;

    // Decode the raw operation field.
    assign op = arith_op_e'(op_sel);

    addsub_operand_sel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_opsel (
        .reg_val  (opnd_b),
        .imm_val  (imm),
        .use_imm  (imm_sel),
        .opnd_out (b_sel)
    );

    addsub_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .op     (op),
        .a      (opnd_a),
        .b      (b_sel),
        .cy_in  (carry_in),
        .result (result_o),
        .flags  (nxt_flags),
        .upd_en (upd_en)
    );

    addsub_flag_reg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .upd_en    (upd_en),
        .new_flags (nxt_flags),
        .ove       (ove_in),
        .carry_q   (carry_o),
        .ovf_q     (ovf_o),
        .trap_q    (range_trap_o)
    );

    // R9: the no-operation code leaves flags alone and never traps.
    assert_nop_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b11) |=> ($stable({carry_o, ovf_o}) && !range_trap_o));

    // R4: no borrow when the first operand is not below the second.
    assert_sub_no_borrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b10 && opnd_a >= b_sel) |=> !carry_o);

    // R1: a wrapped add result implies a carry out.
    assert_add_wrap_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b00 && result_o < opnd_a) |=> carry_o);

    // R2: operands of opposite sign can never overflow an add.
    assert_add_mixed_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'b00 && (opnd_a[DATA_W-1] != b_sel[DATA_W-1])) |=> !ovf_o);

endmodule

// File: tb/addsub_flag_unit_test.sv
module addsub_flag_unit_test;
    localparam int W    = 6;
    localparam int IW   = 3;
    localparam int MASK = (1 << W) - 1;
    localparam int IMSK = (1 << IW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_valid;
    logic [1:0]    op_sel;
    logic [W-1:0]  opnd_a, opnd_b;
    logic [IW-1:0] imm;
    logic          imm_sel, carry_in, ove_in;
    logic [W-1:0]  result_o;
    logic          carry_o, ovf_o, range_trap_o;

    int    checks = 0;
    int    errors = 0;
    logic  exp_cy = 1'b0, exp_ov = 1'b0, exp_trap = 1'b0;
    string exp_tag = "R10";

    always #10 clk = ~clk;

    addsub_flag_unit #(.DATA_W(W), .IMM_W(IW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .imm_sel(imm_sel),
        .carry_in(carry_in), .ove_in(ove_in), .result_o(result_o),
        .carry_o(carry_o), .ovf_o(ovf_o), .range_trap_o(range_trap_o)
    );

    function automatic int sgn(int v);
        return (v >> (W - 1)) & 1;
    endfunction

    task automatic check_bit(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic check_word(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One issue cycle: check the previous cycle's flags, drive, check result.
    task automatic step(bit v, int op, int a, int b, bit isel, int im,
                        bit cin, bit ove, string tag);
        int bb, r, cy, ov;
        @(negedge clk);
        check_bit(exp_tag, "carry", carry_o, exp_cy);
        check_bit(exp_tag, "overflow", ovf_o, exp_ov);
        check_bit(exp_tag, "trap", range_trap_o, exp_trap);
        op_valid = v; op_sel = op[1:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
        imm = im[IW-1:0]; imm_sel = isel; carry_in = cin; ove_in = ove;
        bb = b & MASK;
        if (isel) bb = ((im & IMSK) >= (1 << (IW - 1))) ? ((im & IMSK) | (MASK & ~IMSK)) : (im & IMSK);
        cy = 0; ov = 0; r = 0;
        if (op == 2) begin
            r  = (a - bb) & MASK;
            cy = (a < bb) ? 1 : 0;
            ov = (sgn(a) != sgn(bb) && sgn(r) != sgn(a)) ? 1 : 0;
        end else if (op != 3) begin
            r  = a + bb + ((op == 1) ? int'(cin) : 0);
            cy = (r > MASK) ? 1 : 0;
            r  = r & MASK;
            ov = (sgn(a) == sgn(bb) && sgn(r) != sgn(a)) ? 1 : 0;
        end
        exp_trap = v && op != 3 && ove && (cy != 0 || ov != 0);
        if (v && op != 3) begin
            exp_cy = cy[0];
            exp_ov = ov[0];
        end
        exp_tag = tag;
        #1;
        if (op != 3) check_word(tag, "result", int'(result_o), r);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10: reset clears flags despite a trap-worthy operation at the inputs.
        rst_n = 1'b0; op_valid = 1'b1; op_sel = 2'b00; opnd_a = '1; opnd_b = '1;
        imm = '0; imm_sel = 1'b0; carry_in = 1'b1; ove_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R10", "carry", carry_o, 1'b0);
        check_bit("R10", "overflow", ovf_o, 1'b0);
        check_bit("R10", "trap", range_trap_o, 1'b0);
        op_valid = 1'b0;
        rst_n = 1'b1;

        // R1 R2: exhaustive add.
        for (int a = 0; a <= MASK; a++)
            for (int b = 0; b <= MASK; b++)
                step(1, 0, a, b, 0, 0, 0, (a ^ b) & 1, "R1 R2");
        // R3: exhaustive add with carry, both carry inputs.
        for (int c = 0; c < 2; c++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    step(1, 1, a, b, 0, 0, c[0], b & 1, "R3");
        // R4 R5: exhaustive subtract.
        for (int a = 0; a <= MASK; a++)
            for (int b = 0; b <= MASK; b++)
                step(1, 2, a, b, 0, 0, 0, a & 1, "R4 R5");
        // R6: immediate forms, opnd_b changing but ignored.
        for (int op = 0; op < 3; op++)
            for (int a = 0; a <= MASK; a++)
                for (int im = 0; im <= IMSK; im++)
                    for (int c = 0; c < 2; c++)
                        step(1, op, a, a ^ 21, 1, im, c[0], im[0], "R6");

        // R7: set both flags, idle cycles hold, then a clean op clears both.
        step(1, 0, 32, 32, 0, 0, 0, 0, "R7");
        step(0, 2, 0, 1, 0, 0, 1, 1, "R7");
        step(0, 0, 63, 63, 0, 0, 1, 1, "R7");
        step(1, 0, 1, 1, 0, 0, 0, 1, "R7");
        // R8: trap for one cycle only, and not without the enable.
        step(1, 0, 63, 1, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R8");
        step(1, 2, 0, 1, 0, 0, 0, 0, "R8");
        step(1, 2, 0, 1, 0, 0, 0, 1, "R8");
        step(1, 1, 0, 0, 0, 0, 1, 1, "R8");
        // R9: the no-operation code with trap-worthy operands.
        step(1, 0, 31, 1, 0, 0, 0, 0, "R9");
        step(1, 3, 63, 63, 0, 0, 1, 1, "R9");
        step(1, 3, 32, 63, 0, 0, 1, 1, "R9");
        // R11: zero operands take part in the arithmetic as presented.
        step(1, 2, 0, 5, 0, 0, 0, 1, "R11");
        step(1, 0, 0, 0, 0, 0, 0, 1, "R11");
        step(1, 1, 0, 63, 0, 0, 1, 1, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        @(negedge clk);
        finish_run();
    end
endmodule